// File: doc/BRIEF.md
# Command Packet Word Packer

This block turns a host command into the sequence of 32-bit words that a transmit FIFO expects. A command carries a 2-bit virtual channel, a 6-bit data type, a byte length and three flags. Its bytes come in one at a time on a separate valid/ready stream. The packer first builds a header word. The header holds the channel and type in its low byte and carries up to the first two payload bytes above them. Any bytes left after that are packed four to a word, least significant lane first. Each finished word goes out with a single write strobe, and a FIFO-full input holds the word back.

While it accepts a command, the packer also works out three side signals. It decides whether the command fits the small host FIFO or needs the larger video FIFO. It decides whether a bus turnaround must follow the transfer, and whether the link stays in high-speed mode. A command too long for even the video FIFO is rejected: no bytes are taken and no words are written. When a command finishes, a one-cycle done pulse reports the byte count that the link will carry for a plain write.

Top module: `cmd_word_packer`

## Requirements
- R1: The first word written for an accepted command is the header: bits 7:6 hold the virtual channel, and bits 5:0 hold the data type.
- R2: In the header word, payload byte 0 (if the length is at least 1) sits in bits 15:8 and byte 1 (if the length is at least 2) in bits 23:16. Header lanes with no byte, and bits 31:24, are zero.
- R3: Payload bytes from index 2 onward are packed four per word, with the lowest index in bits 7:0. The final word is zero-padded. An accepted command of length L writes exactly 1 + ceil(max(L-2,0)/4) words.
- R4: `fifoWrEn` is never high while `fifoFull` is high. A word blocked by a full FIFO is written later, unchanged.
- R5: Exactly L bytes are taken (`byteValid && byteReady`) for an accepted command. `byteReady` stays low once all L bytes are in, and low while idle.
- R6: From the cycle after acceptance, `useVideoFifo` is 1 when L exceeds 4 × HOST_DEPTH bytes (256 by default), and 0 otherwise.
- R7: A command with L greater than 4 × VIDEO_DEPTH bytes (1920 by default) gives a one-cycle `cmdReject` in the cycle after it is offered. It takes no bytes, writes no words and gives no `cmdDone`.
- R8: From the cycle after acceptance, `turnaroundReq` equals `cmdAckReq OR cmdReadReq` of the accepted command.
- R9: From the cycle after acceptance, `highSpeed` equals NOT `cmdLowPower` of the accepted command.
- R10: `cmdDone` pulses for one cycle, in the cycle after the last word is written. `doneCount` then shows 4 + L when no turnaround was requested, and 0 when one was.
- R11: `cmdReady` is high only while the packer is idle. A command is taken in a cycle where `cmdValid` and `cmdReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Packer idle, will take a command |
| cmdVc | input | 2 | Virtual channel |
| cmdType | input | 6 | Packet data type |
| cmdLen | input | LEN_W | Payload length in bytes |
| cmdAckReq | input | 1 | Acknowledge explicitly requested |
| cmdReadReq | input | 1 | A read reply buffer is supplied |
| cmdLowPower | input | 1 | Send in low-power mode |
| byteValid | input | 1 | Payload byte offered |
| byteReady | output | 1 | Payload byte taken this cycle if valid |
| byteData | input | 8 | Payload byte |
| fifoFull | input | 1 | Transmit FIFO cannot take a word |
| fifoWrEn | output | 1 | Write strobe for one word |
| fifoWrData | output | 32 | Word being written |
| useVideoFifo | output | 1 | Command routed to the large FIFO |
| turnaroundReq | output | 1 | Bus turnaround after transfer |
| highSpeed | output | 1 | High-speed transfer mode |
| cmdDone | output | 1 | One-cycle completion pulse |
| doneCount | output | LEN_W | Reported byte count at completion |
| cmdReject | output | 1 | One-cycle too-long rejection pulse |

## Verification
The bench aims at the length edges where the word count changes: lengths 0, 1, 2, 3, 6 and 7, where a header-only word, a missing lane or a one-byte tail word could go wrong. A packer that mis-counted lanes would write an extra word or put a stray byte in bits 31:24. It also probes the FIFO thresholds at 256/257 and 1920/1921 bytes. An off-by-one compare there would route a full-length host command to the video FIFO, or would reject a command that still fits. Random FIFO-full and byte-valid gaps check that a blocked word is neither dropped nor written twice, and that no byte is taken past the end of a command.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  typedef struct packed {
    logic loadCmd;
    logic takeByte;
    logic wordWritten;
  } pkStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PACK = 2'd1,
    S_DONE = 2'd2,
    S_REJ  = 2'd3
  } pkState_t;

endpackage

// File: rtl/cwp_datapath.sv
module cwp_datapath
  import cwp_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int HOST_DEPTH  = 64,
  parameter int VIDEO_DEPTH = 480
) (
  input  logic             clk,
  input  logic             rstN,
  input  pkStrobe_t        strobe,
  input  logic [1:0]       cmdVc,
  input  logic [5:0]       cmdType,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             cmdAckReq,
  input  logic             cmdReadReq,
  input  logic             cmdLowPower,
  input  logic [7:0]       byteData,
  output logic [31:0]      wordOut,
  output logic             wordFull,
  output logic             lastWord,
  output logic             tooLong,
  output logic             useVideoFifo,
  output logic             turnaroundReq,
  output logic             highSpeed,
  output logic [LEN_W-1:0] doneCount
);

  localparam int HOST_BYTES  = 4 * HOST_DEPTH;
  localparam int VIDEO_BYTES = 4 * VIDEO_DEPTH;
  localparam int LANES       = 4;

  logic [31:0]      accWord;
  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] lenReg;
  logic [2:0]       slot;
  logic             inHeader;
  logic [2:0]       cap;
  logic [1:0]       lane;

  // Header word has two free lanes above channel/type; payload words four.
  assign cap      = inHeader ? 3'd2 : 3'd4;
  assign lane     = inHeader ? (slot[1:0] + 2'd1) : slot[1:0];
  assign wordFull = (slot == cap) || (remaining == '0);
  assign lastWord = (remaining == '0);
  assign tooLong  = 32'(cmdLen) > VIDEO_BYTES;
  assign wordOut  = accWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accWord       <= '0;
      remaining     <= '0;
      lenReg        <= '0;
      slot          <= '0;
      inHeader      <= 1'b0;
      useVideoFifo  <= 1'b0;
      turnaroundReq <= 1'b0;
      highSpeed     <= 1'b0;
    end else if (strobe.loadCmd) begin
      accWord       <= {24'd0, cmdVc, cmdType};
      remaining     <= cmdLen;
      lenReg        <= cmdLen;
      slot          <= '0;
      inHeader      <= 1'b1;
      useVideoFifo  <= 32'(cmdLen) > HOST_BYTES;
      turnaroundReq <= cmdAckReq | cmdReadReq;
      highSpeed     <= ~cmdLowPower;
    end else if (strobe.wordWritten) begin
      accWord  <= '0;
      slot     <= '0;
      inHeader <= 1'b0;
    end else if (strobe.takeByte) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane == 2'(i)) accWord[8*i +: 8] <= byteData;
      end
      remaining <= remaining - LEN_W'(1);
      slot      <= slot + 3'd1;
    end
  end

  assign doneCount = turnaroundReq ? '0 : (lenReg + LEN_W'(4));

endmodule

// File: rtl/cwp_control.sv
module cwp_control
  import cwp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      tooLong,
  input  logic      byteValid,
  input  logic      fifoFull,
  input  logic      wordFull,
  input  logic      lastWord,
  output pkStrobe_t strobe,
  output logic      cmdReady,
  output logic      byteReady,
  output logic      fifoWrEn,
  output logic      cmdDone,
  output logic      cmdReject
);

  pkState_t state, nextState;

  always_comb begin
    cmdReady  = (state == S_IDLE);
    byteReady = (state == S_PACK) && !wordFull;
    fifoWrEn  = (state == S_PACK) && wordFull && !fifoFull;
    cmdDone   = (state == S_DONE);
    cmdReject = (state == S_REJ);

    strobe.loadCmd     = cmdReady && cmdValid && !tooLong;
    strobe.takeByte    = byteReady && byteValid;
    strobe.wordWritten = fifoWrEn;

    nextState = state;
    unique case (state)
      S_IDLE: if (cmdValid) nextState = tooLong ? S_REJ : S_PACK;
      S_PACK: if (fifoWrEn && lastWord) nextState = S_DONE;
      S_DONE: nextState = S_IDLE;
      S_REJ:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/cmd_word_packer.sv
module cmd_word_packer
  import cwp_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int HOST_DEPTH  = 64,
  parameter int VIDEO_DEPTH = 480
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdVc,
  input  logic [5:0]       cmdType,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             cmdAckReq,
  input  logic             cmdReadReq,
  input  logic             cmdLowPower,
  input  logic             byteValid,
  output logic             byteReady,
  input  logic [7:0]       byteData,
  input  logic             fifoFull,
  output logic             fifoWrEn,
  output logic [31:0]      fifoWrData,
  output logic             useVideoFifo,
  output logic             turnaroundReq,
  output logic             highSpeed,
  output logic             cmdDone,
  output logic [LEN_W-1:0] doneCount,
  output logic             cmdReject
);

  pkStrobe_t strobe;
  logic      wordFull;
  logic      lastWord;
  logic      tooLong;

  cwp_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .tooLong   (tooLong),
    .byteValid (byteValid),
    .fifoFull  (fifoFull),
    .wordFull  (wordFull),
    .lastWord  (lastWord),
    .strobe    (strobe),
    .cmdReady  (cmdReady),
    .byteReady (byteReady),
    .fifoWrEn  (fifoWrEn),
    .cmdDone   (cmdDone),
    .cmdReject (cmdReject)
  );

  cwp_datapath #(
    .LEN_W       (LEN_W),
    .HOST_DEPTH  (HOST_DEPTH),
    .VIDEO_DEPTH (VIDEO_DEPTH)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cmdVc         (cmdVc),
    .cmdType       (cmdType),
    .cmdLen        (cmdLen),
    .cmdAckReq     (cmdAckReq),
    .cmdReadReq    (cmdReadReq),
    .cmdLowPower   (cmdLowPower),
    .byteData      (byteData),
    .wordOut       (fifoWrData),
    .wordFull      (wordFull),
    .lastWord      (lastWord),
    .tooLong       (tooLong),
    .useVideoFifo  (useVideoFifo),
    .turnaroundReq (turnaroundReq),
    .highSpeed     (highSpeed),
    .doneCount     (doneCount)
  );

endmodule

// File: rtl/cwp_checker.sv
module cwp_checker (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic byteReady,
  input logic fifoFull,
  input logic fifoWrEn,
  input logic cmdDone,
  input logic cmdReject
);

  p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoWrEn);

  p_no_byte_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !cmdReady);

  p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> (!fifoWrEn && !cmdDone && !byteReady));

  p_reject_after_offer_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $past(cmdValid && cmdReady));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> $past(fifoWrEn));

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!fifoWrEn && !cmdDone && !cmdReject));

endmodule

bind cmd_word_packer cwp_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .byteReady (byteReady),
  .fifoFull  (fifoFull),
  .fifoWrEn  (fifoWrEn),
  .cmdDone   (cmdDone),
  .cmdReject (cmdReject)
);

// File: tb/sim_cmd_word_packer.sv
module sim_cmd_word_packer;

  localparam int LEN_W     = 16;
  localparam int HOST_LIM  = 256;
  localparam int VIDEO_LIM = 1920;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic             cmdReady;
  logic [1:0]       cmdVc = '0;
  logic [5:0]       cmdType = '0;
  logic [LEN_W-1:0] cmdLen = '0;
  logic             cmdAckReq = 1'b0;
  logic             cmdReadReq = 1'b0;
  logic             cmdLowPower = 1'b0;
  logic             byteValid = 1'b0;
  logic             byteReady;
  logic [7:0]       byteData = '0;
  logic             fifoFull = 1'b0;
  logic             fifoWrEn;
  logic [31:0]      fifoWrData;
  logic             useVideoFifo;
  logic             turnaroundReq;
  logic             highSpeed;
  logic             cmdDone;
  logic [LEN_W-1:0] doneCount;
  logic             cmdReject;

  always #5 clk = ~clk;

  cmd_word_packer u0 (.*);

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  logic [7:0]  bytes [0:2047];
  logic [31:0] got   [0:1023];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expWords(input int len);
    return (len <= 2) ? 1 : 1 + (len - 2 + 3) / 4;
  endfunction

  function automatic logic [31:0] expWord(input int k, input int len,
                                          input logic [1:0] vc, input logic [5:0] dt);
    logic [31:0] w;
    w = '0;
    if (k == 0) begin
      w[7:0] = {vc, dt};
      if (len > 0) w[15:8]  = bytes[0];
      if (len > 1) w[23:16] = bytes[1];
    end else begin
      for (int j = 0; j < 4; j++) begin
        int idx;
        idx = 2 + 4 * (k - 1) + j;
        if (idx < len) w[8*j +: 8] = bytes[idx];
      end
    end
    return w;
  endfunction

  task automatic runCmd(input logic [1:0] vc, input logic [5:0] dt, input int len,
                        input bit ack, input bit rd, input bit lp,
                        input int fullPct, input int validPct);
    int  nw, bi, cyc;
    bit  sawDone, sawRej, flagsDone, fullViol, extra, expRej, wordsOk;
    expRej = len > VIDEO_LIM;
    for (int i = 0; i < 2048; i++) bytes[i] = 8'($urandom);
    @(negedge clk);
    cmdValid = 1'b1; cmdVc = vc; cmdType = dt; cmdLen = LEN_W'(len);
    cmdAckReq = ack; cmdReadReq = rd; cmdLowPower = lp;
    #1;
    chk(cmdReady == 1'b1, "R11", "ready when idle", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    nw = 0; bi = 0; cyc = 0;
    sawDone = 0; sawRej = 0; flagsDone = 0; fullViol = 0; extra = 0;
    while (!sawDone && !sawRej && cyc < 6000) begin
      byteValid = (bi < len) && (($urandom % 100) < validPct);
      byteData  = (bi < 2048) ? bytes[bi] : 8'h00;
      fifoFull  = ($urandom % 100) < fullPct;
      #1;
      if (!flagsDone && !expRej) begin
        flagsDone = 1;
        chk(cmdReady == 1'b0, "R11", "ready low while busy", cmdReady, 0);
        chk(useVideoFifo == (len > HOST_LIM), "R6", "fifo select", useVideoFifo, len > HOST_LIM);
        chk(turnaroundReq == (ack | rd), "R8", "turnaround", turnaroundReq, ack | rd);
        chk(highSpeed == !lp, "R9", "high speed", highSpeed, !lp);
      end
      if (fifoFull && fifoWrEn) fullViol = 1;
      if (byteReady && bi >= len) extra = 1;
      if (fifoWrEn && nw < 1024) begin got[nw] = fifoWrData; nw++; end
      if (byteValid && byteReady) bi++;
      if (cmdDone) begin
        sawDone = 1;
        chk(doneCount == ((ack | rd) ? 0 : 4 + len), "R10", "done count",
            doneCount, (ack | rd) ? 0 : 4 + len);
      end
      if (cmdReject) sawRej = 1;
      @(negedge clk);
      cyc++;
    end
    byteValid = 1'b0; fifoFull = 1'b0;
    if (expRej) begin
      chk(sawRej && !sawDone, "R7", "reject pulse", sawRej, 1);
      chk(nw == 0 && bi == 0, "R7", "nothing moved on reject", nw + bi, 0);
    end else begin
      chk(sawDone && !sawRej, "R10", "done seen", sawDone, 1);
      chk(bi == len && !extra, "R5", "bytes taken", bi, len);
      chk(!fullViol, "R4", "write while full", fullViol, 0);
      chk(nw == expWords(len), "R3", "word count", nw, expWords(len));
      if (nw > 0) begin
        chk(got[0][7:0] == {vc, dt}, "R1", "header channel/type", got[0][7:0], {vc, dt});
        chk(got[0] == expWord(0, len, vc, dt), "R2", "header bytes", got[0], expWord(0, len, vc, dt));
      end
      wordsOk = 1;
      for (int k = 1; k < nw; k++)
        if (got[k] != expWord(k, len, vc, dt)) begin
          wordsOk = 0;
          chk(0, "R3", $sformatf("payload word %0d", k), got[k], expWord(k, len, vc, dt));
        end
      if (wordsOk) chk(1, "R3", "payload words", 0, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(cmdReady == 1'b1 && fifoWrEn == 1'b0 && byteReady == 1'b0 &&
        cmdDone == 1'b0 && cmdReject == 1'b0, "R11", "reset state",
        {cmdReady, fifoWrEn, byteReady, cmdDone, cmdReject}, 5'b10000);
    // Directed length edges
    runCmd(2'd1, 6'h05, 0, 0, 0, 0, 0, 100);
    runCmd(2'd2, 6'h15, 1, 1, 0, 1, 30, 70);
    runCmd(2'd3, 6'h39, 2, 0, 1, 0, 30, 70);
    runCmd(2'd0, 6'h29, 3, 0, 0, 0, 50, 50);
    runCmd(2'd1, 6'h3F, 6, 0, 0, 1, 60, 80);
    runCmd(2'd2, 6'h2A, 7, 1, 1, 0, 20, 90);
    runCmd(2'd3, 6'h39, HOST_LIM, 0, 0, 0, 20, 80);
    runCmd(2'd0, 6'h39, HOST_LIM + 1, 0, 0, 0, 20, 80);
    runCmd(2'd1, 6'h39, VIDEO_LIM, 0, 0, 0, 10, 90);
    runCmd(2'd2, 6'h39, VIDEO_LIM + 1, 1, 0, 0, 10, 90);
    // Constrained random
    for (int n = 0; n < 40; n++)
      runCmd(2'($urandom), 6'($urandom), int'($urandom % 41),
             1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
             int'($urandom % 60), 30 + int'($urandom % 70));
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule